// File: doc/BRIEF.md
# PAL Interlaced Composite Sync Generator

This block produces the complete sync timing for a 625-line, two-field interlaced monochrome PAL picture from one pixel clock. The output is a registered, active-low composite sync. It carries a normal line pulse on ordinary lines. During each field-blanking interval it carries half-line equalising pulses and serrated broad pulses. Alongside the sync it gives an active-video enable, pixel column and frame row coordinates for fetching greyscale samples from a frame store, and back-porch burst-gate and black-level clamp-gate strobes.

Internally a horizontal counter marks two half-line points in every line. A line counter and a half-line flag step at those points. A small state machine steps once per half-line through the sequence normal, five equalising half-lines, five broad half-lines, five equalising half-lines, and back to normal. The equalising, broad and line pulse shapes are formed on every half-line. The state machine picks which one reaches the output register. The coordinate and strobe outputs pass through the same single register stage, so they stay aligned with the sync.

The pixel rate `CLK_HZ` is a parameter. The line length is `CLK_HZ/15625` clocks, with half-line `HALF` = half of that. The pulse widths in clocks are rounded down from the nominal times: line pulse `HS` = `CLK_HZ*47/10^7` (4.7 us), equalising pulse `EQ` = `(CLK_HZ/1000)*235/10^5` (2.35 us), broad pulse `BR` = `HALF-HS`. The burst gate starts at `(CLK_HZ/1000)*56/10^4` (5.6 us) and lasts `(CLK_HZ/1000)*225/10^5` clocks. The clamp gate starts where the burst gate ends and lasts `(CLK_HZ/1000)*15/10^4` clocks. The default is 13.5 MHz with 864 clocks per line.

Top module: `pal_csync_gen`

## Requirements
Counting positions: after reset is released, the output values seen after the k-th rising edge describe position p = k-1. For that position, h = p mod (line clocks) and the half-line index is n = (p div HALF) mod 1250. The line is n div 2 + 1, and the half is n mod 2, where 0 means the first half.

- R1: On a normal half-line with half = 0, `sync_n` is 0 for h < HS and 1 for the rest of that half-line.
- R2: On a normal half-line with half = 1, `sync_n` stays 1 for the whole half-line.
- R3: Half-lines n in 1245..1249, 5..9, 620..624 and 630..634 are equalising. On these, `sync_n` is 0 for the first EQ clocks of the half-line and 1 for the rest.
- R4: Half-lines n in 0..4 and 625..629 are broad. On these, `sync_n` is 0 for the first BR clocks of the half-line and 1 for the rest. All half-lines not named in R3 or R4 are normal.
- R5: `field_o` is 0 for n in 0..624 and 1 for n in 625..1249. It therefore changes at a line start and at mid-line of line 313.
- R6: `active_o` is 1 exactly when ACT_START <= h < ACT_START+ACT_W and the line is in F1_FIRST..F1_LAST or in F2_FIRST..F2_LAST. The defaults for those line ranges are 23..310 and 336..622.
- R7: While `active_o` is 1, `px_x` = h-ACT_START. `px_y` = 2*(line-F1_FIRST) on first-field lines and 2*(line-F2_FIRST)+1 on second-field lines. While `active_o` is 0, both are 0.
- R8: `burst_o` is 1 exactly on normal half-lines with half = 0 and h in [burst start, burst start + burst width).
- R9: `clamp_o` is 1 exactly on normal half-lines with half = 0 and h in [clamp start, clamp start + clamp width).
- R10: While `rst` is 1 after a clock edge, `sync_n` is 1 and every other output is 0. The first position after reset is line 1, half 0, which is a broad half-line. All outputs are registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | output | 1 | Registered composite sync, active low |
| field_o | output | 1 | Field parity, 0 = first field |
| active_o | output | 1 | Active-video enable |
| px_x | output | XW | Pixel column within the active line |
| px_y | output | YW | Interlaced frame row of the active line |
| burst_o | output | 1 | Back-porch burst gate |
| clamp_o | output | 1 | Black-level clamp gate |

## Verification
A wrong half-line flag or line count moves the field-blanking pattern. That error appears on `sync_n` within a half-line of the bad state as a pulse of the wrong width: equalising where broad was due, or a line pulse at mid-line. A state machine that leaves its sequence one step early or late shows at one edge of the broad group, or of an equalising group, within five half-lines. A misaligned coordinate pipeline shows in the first active pixel of any active line as a wrong `px_x` or an `active_o` edge one clock off. Sweeping more than two full frames with every output compared on every clock exposes each of these within one frame.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;
  typedef enum logic [1:0] {
    FS_NORM     = 2'd0,
    FS_EQ_PRE   = 2'd1,
    FS_BROAD    = 2'd2,
    FS_EQ_POST  = 2'd3
  } fsync_e;
endpackage

// File: rtl/pal_hcount.sv
module pal_hcount #(
  parameter int H_TOTAL = 864,
  parameter int HW      = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic          at_mid,
  output logic          at_end
);
  localparam int HALF = H_TOTAL / 2;

  assign at_mid = (hcnt == HW'(HALF - 1));
  assign at_end = (hcnt == HW'(H_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst)         hcnt <= '0;
    else if (at_end) hcnt <= '0;
    else             hcnt <= hcnt + 1'b1;
  end

  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (hcnt == '0)); // R1
endmodule

// File: rtl/pal_vseq.sv
module pal_vseq
  import pal_sync_pkg::*;
#(
  parameter int FRAME_LINES = 625,
  parameter int SEQ_HL      = 5,
  parameter int LW          = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          at_mid,
  input  logic          at_end,
  output logic [LW-1:0] line_o,
  output logic          half_o,
  output logic          field_o,
  output fsync_e        state_o
);
  localparam int HLT = 2 * FRAME_LINES;
  localparam int PW  = (SEQ_HL > 1) ? $clog2(SEQ_HL) : 1;

  logic [LW-1:0] line_q, line_n;
  logic          half_q, half_n, field_q;
  fsync_e        state_q;
  logic [PW-1:0] ph_q;
  int            hl_n;

  always_comb begin
    line_n = line_q;
    half_n = half_q;
    if (at_end) begin
      half_n = 1'b0;
      line_n = (line_q == LW'(FRAME_LINES)) ? LW'(1) : line_q + 1'b1;
    end else if (at_mid) begin
      half_n = 1'b1;
    end
    hl_n = 2 * (int'(line_n) - 1) + int'(half_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= LW'(1);
      half_q  <= 1'b0;
      field_q <= 1'b0;
      state_q <= FS_BROAD;
      ph_q    <= '0;
    end else if (at_mid || at_end) begin
      line_q <= line_n;
      half_q <= half_n;
      if (hl_n == 0)                field_q <= 1'b0;
      else if (hl_n == FRAME_LINES) field_q <= 1'b1;
      if (state_q == FS_NORM) begin
        if (hl_n == HLT - SEQ_HL || hl_n == FRAME_LINES - SEQ_HL) begin
          state_q <= FS_EQ_PRE;
          ph_q    <= '0;
        end
      end else if (ph_q == PW'(SEQ_HL - 1)) begin
        ph_q <= '0;
        case (state_q)
          FS_EQ_PRE: state_q <= FS_BROAD;
          FS_BROAD:  state_q <= FS_EQ_POST;
          default:   state_q <= FS_NORM;
        endcase
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign line_o  = line_q;
  assign half_o  = half_q;
  assign field_o = field_q;
  assign state_o = state_q;

  AST_HALF_MID: assert property (@(posedge clk) disable iff (rst)
    at_mid |=> half_q); // R3
  AST_HALF_END: assert property (@(posedge clk) disable iff (rst)
    at_end |=> !half_q); // R1
  AST_BROAD_EDGE: assert property (@(posedge clk) disable iff (rst)
    (state_q == FS_BROAD && ph_q == '0) |->
      ((!half_q && line_q == LW'(1)) ||
       (half_q && line_q == LW'(FRAME_LINES / 2 + 1)))); // R4
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (line_q != '0 && int'(line_q) <= FRAME_LINES)); // R5
endmodule

// File: rtl/pal_pulse_mix.sv
module pal_pulse_mix
  import pal_sync_pkg::*;
#(
  parameter int H_TOTAL     = 864,
  parameter int HS_W        = 63,
  parameter int EQ_W        = 31,
  parameter int BR_W        = 369,
  parameter int BURST_START = 75,
  parameter int BURST_W     = 30,
  parameter int CLAMP_START = 105,
  parameter int CLAMP_W     = 20,
  parameter int HW          = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic          half,
  input  fsync_e        state,
  output logic          sync_n,
  output logic          burst_o,
  output logic          clamp_o
);
  localparam int HALF = H_TOTAL / 2;

  logic [HW-1:0] pos;
  logic eq_low, broad_low, line_low, sync_low, burst_win, clamp_win;

  always_comb begin
    pos       = half ? hcnt - HW'(HALF) : hcnt;
    eq_low    = pos < HW'(EQ_W);
    broad_low = pos < HW'(BR_W);
    line_low  = !half && (hcnt < HW'(HS_W));
    case (state)
      FS_BROAD:              sync_low = broad_low;
      FS_EQ_PRE, FS_EQ_POST: sync_low = eq_low;
      default:               sync_low = line_low;
    endcase
    burst_win = (state == FS_NORM) && !half &&
                hcnt >= HW'(BURST_START) && hcnt < HW'(BURST_START + BURST_W);
    clamp_win = (state == FS_NORM) && !half &&
                hcnt >= HW'(CLAMP_START) && hcnt < HW'(CLAMP_START + CLAMP_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_n  <= 1'b1;
      burst_o <= 1'b0;
      clamp_o <= 1'b0;
    end else begin
      sync_n  <= !sync_low;
      burst_o <= burst_win;
      clamp_o <= clamp_win;
    end
  end

  AST_MIDLINE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == FS_NORM && half) |=> sync_n); // R2
  AST_GATE_OFF_SYNC: assert property (@(posedge clk) disable iff (rst)
    (burst_o || clamp_o) |-> sync_n); // R8
  AST_GATES_APART: assert property (@(posedge clk) disable iff (rst)
    !(burst_o && clamp_o)); // R9
endmodule

// File: rtl/pal_pix_coord.sv
module pal_pix_coord #(
  parameter int H_TOTAL     = 864,
  parameter int FRAME_LINES = 625,
  parameter int ACT_START   = 132,
  parameter int ACT_W       = 720,
  parameter int F1_FIRST    = 23,
  parameter int F1_LAST     = 310,
  parameter int F2_FIRST    = 336,
  parameter int F2_LAST     = 622,
  parameter int HW          = $clog2(H_TOTAL),
  parameter int LW          = $clog2(FRAME_LINES + 1),
  parameter int XW          = $clog2(ACT_W),
  parameter int YW          = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic [LW-1:0] line,
  output logic          active_o,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y
);
  logic in_f1, in_f2, h_act, act;
  logic [XW-1:0] x_n;
  logic [YW-1:0] y_n;

  always_comb begin
    in_f1 = int'(line) >= F1_FIRST && int'(line) <= F1_LAST;
    in_f2 = int'(line) >= F2_FIRST && int'(line) <= F2_LAST;
    h_act = int'(hcnt) >= ACT_START && int'(hcnt) < ACT_START + ACT_W;
    act   = h_act && (in_f1 || in_f2);
    x_n   = '0;
    y_n   = '0;
    if (act) begin
      x_n = XW'(int'(hcnt) - ACT_START);
      y_n = in_f2 ? YW'(2 * (int'(line) - F2_FIRST) + 1)
                  : YW'(2 * (int'(line) - F1_FIRST));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      px_x     <= '0;
      px_y     <= '0;
    end else begin
      active_o <= act;
      px_x     <= x_n;
      px_y     <= y_n;
    end
  end

  AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
    (active_o && px_x != XW'(ACT_W - 1)) |=>
      (active_o && px_x == $past(px_x) + 1'b1)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> (px_x == '0 && px_y == '0)); // R7
endmodule

// File: rtl/pal_csync_gen.sv
module pal_csync_gen
  import pal_sync_pkg::*;
#(
  parameter int CLK_HZ      = 13_500_000,
  parameter int FRAME_LINES = 625,
  parameter int SEQ_HL      = 5,
  parameter int ACT_START   = 132,
  parameter int ACT_W       = 720,
  parameter int F1_FIRST    = 23,
  parameter int F1_LAST     = 310,
  parameter int F2_FIRST    = 336,
  parameter int F2_LAST     = 622,
  parameter int XW          = $clog2(ACT_W),
  parameter int YW          = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          sync_n,
  output logic          field_o,
  output logic          active_o,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic          burst_o,
  output logic          clamp_o
);
  localparam int KHZ         = CLK_HZ / 1000;
  localparam int H_TOTAL     = CLK_HZ / 15625;
  localparam int HALF        = H_TOTAL / 2;
  localparam int HS_W        = CLK_HZ * 47 / 10_000_000;
  localparam int EQ_W        = KHZ * 235 / 100_000;
  localparam int BR_W        = HALF - HS_W;
  localparam int BURST_START = KHZ * 56 / 10_000;
  localparam int BURST_W     = KHZ * 225 / 100_000;
  localparam int CLAMP_START = BURST_START + BURST_W;
  localparam int CLAMP_W     = KHZ * 15 / 10_000;
  localparam int HW          = $clog2(H_TOTAL);
  localparam int LW          = $clog2(FRAME_LINES + 1);

  logic [HW-1:0] hcnt;
  logic          at_mid, at_end, half, field_q;
  logic [LW-1:0] line;
  fsync_e        state;

  pal_hcount #(.H_TOTAL(H_TOTAL), .HW(HW)) u_h (
    .clk(clk), .rst(rst), .hcnt(hcnt), .at_mid(at_mid), .at_end(at_end));

  pal_vseq #(.FRAME_LINES(FRAME_LINES), .SEQ_HL(SEQ_HL), .LW(LW)) u_v (
    .clk(clk), .rst(rst), .at_mid(at_mid), .at_end(at_end),
    .line_o(line), .half_o(half), .field_o(field_q), .state_o(state));

  pal_pulse_mix #(
    .H_TOTAL(H_TOTAL), .HS_W(HS_W), .EQ_W(EQ_W), .BR_W(BR_W),
    .BURST_START(BURST_START), .BURST_W(BURST_W),
    .CLAMP_START(CLAMP_START), .CLAMP_W(CLAMP_W), .HW(HW)
  ) u_mix (
    .clk(clk), .rst(rst), .hcnt(hcnt), .half(half), .state(state),
    .sync_n(sync_n), .burst_o(burst_o), .clamp_o(clamp_o));

  pal_pix_coord #(
    .H_TOTAL(H_TOTAL), .FRAME_LINES(FRAME_LINES),
    .ACT_START(ACT_START), .ACT_W(ACT_W),
    .F1_FIRST(F1_FIRST), .F1_LAST(F1_LAST),
    .F2_FIRST(F2_FIRST), .F2_LAST(F2_LAST),
    .HW(HW), .LW(LW), .XW(XW), .YW(YW)
  ) u_pix (
    .clk(clk), .rst(rst), .hcnt(hcnt), .line(line),
    .active_o(active_o), .px_x(px_x), .px_y(px_y));

  always_ff @(posedge clk) begin
    if (rst) field_o <= 1'b0;
    else     field_o <= field_q;
  end

  AST_ACTIVE_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (sync_n && !burst_o && !clamp_o)); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (sync_n && !active_o && !field_o && !burst_o && !clamp_o)); // R10
endmodule

// File: tb/sim_pal_csync_gen.sv
`timescale 1ns/1ps
module sim_pal_csync_gen;
  localparam int CLK_HZ = 1_000_000;
  localparam int AS = 10, AW = 50;
  localparam int XW = $clog2(AW), YW = $clog2(625);
  localparam int KHZ = CLK_HZ / 1000;
  localparam int H = CLK_HZ / 15625, HALF = H / 2;
  localparam int HS = CLK_HZ * 47 / 10_000_000;
  localparam int EQ = KHZ * 235 / 100_000;
  localparam int BR = HALF - HS;
  localparam int BS = KHZ * 56 / 10_000, BWD = KHZ * 225 / 100_000;
  localparam int CS = BS + BWD, CWD = KHZ * 15 / 10_000;
  localparam int RUN = 2 * 625 * H + 300;

  logic clk = 0, rst = 1;
  logic sync_n, field_o, active_o, burst_o, clamp_o;
  logic [XW-1:0] px_x;
  logic [YW-1:0] px_y;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pal_csync_gen #(.CLK_HZ(CLK_HZ), .ACT_START(AS), .ACT_W(AW)) u0 (
    .clk(clk), .rst(rst), .sync_n(sync_n), .field_o(field_o),
    .active_o(active_o), .px_x(px_x), .px_y(px_y),
    .burst_o(burst_o), .clamp_o(clamp_o));

  task automatic chk(input string tag, input int p, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", tag, p, act, exp);
    end
  endtask

  // kind: 0 normal, 1 equalising, 2 broad
  function automatic int kind_of(input int n);
    if (n < 5 || (n >= 625 && n < 630)) return 2;
    if (n >= 1245 || (n >= 5 && n < 10) || (n >= 620 && n < 625) ||
        (n >= 630 && n < 635)) return 1;
    return 0;
  endfunction

  task automatic check_pos(input int p);
    int h, n, ln, hf, ps, k, lo, act, x, y;
    string tg;
    h  = p % H;
    n  = (p / HALF) % 1250;
    ln = n / 2 + 1;
    hf = n % 2;
    ps = h % HALF;
    k  = kind_of(n);
    if (k == 2)      begin lo = (ps < BR); tg = "R4 broad"; end
    else if (k == 1) begin lo = (ps < EQ); tg = "R3 equalising"; end
    else if (hf == 0) begin lo = (h < HS); tg = "R1 line sync"; end
    else             begin lo = 0; tg = "R2 mid-line quiet"; end
    chk(tg, p, int'(sync_n), lo ? 0 : 1);
    chk("R5 field", p, int'(field_o), (n >= 625) ? 1 : 0);
    act = (h >= AS && h < AS + AW) &&
          ((ln >= 23 && ln <= 310) || (ln >= 336 && ln <= 622));
    chk("R6 active", p, int'(active_o), act);
    x = act ? h - AS : 0;
    y = act ? ((ln >= 336) ? 2 * (ln - 336) + 1 : 2 * (ln - 23)) : 0;
    chk("R7 px_x", p, int'(px_x), x);
    chk("R7 px_y", p, int'(px_y), y);
    chk("R8 burst", p, int'(burst_o), (k == 0 && hf == 0 && h >= BS && h < BS + BWD) ? 1 : 0);
    chk("R9 clamp", p, int'(clamp_o), (k == 0 && hf == 0 && h >= CS && h < CS + CWD) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset sync_n", -1, int'(sync_n), 1);
    chk("R10 reset active", -1, int'(active_o), 0);
    chk("R10 reset field", -1, int'(field_o), 0);
    chk("R10 reset gates", -1, int'(burst_o | clamp_o), 0);
    chk("R10 reset coords", -1, int'(px_x) + int'(px_y), 0);
    rst = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 first position broad", 0, int'(sync_n), 0);
    check_pos(0);
    for (int k = 2; k <= RUN; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_pos(k - 1);
    end
    // reset in mid-frame returns to the idle values and restarts at position 0
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 mid-run reset sync_n", -1, int'(sync_n), 1);
    chk("R10 mid-run reset field", -1, int'(field_o), 0);
    rst = 0;
    for (int k = 1; k <= 3 * H; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_pos(k - 1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(190_000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule